// File: doc/BRIEF.md
# Asynchronous static memory access sequencer

This block turns single read and write requests from an on-chip requester into asynchronous access cycles on an external NOR Flash, SRAM or PSRAM device. Each access runs through a fixed sequence of phases: address setup, address hold (multiplexed mode only), data setup and bus turnaround. Every phase length is counted in system clock cycles and taken from configuration inputs. The minimum legal length differs from phase to phase.

The requester presents the bank, the address, the direction and the write data with `req_valid` and holds them until `req_ack` pulses. For a read, `rd_data` carries the word when `req_ack` pulses. On the memory side the block drives four active-low chip selects, an active-low output enable, an active-low write enable, an active-low address-valid strobe, a 26-bit address bus and a bidirectional 16-bit data bus. In multiplexed mode the low address bits also travel on the data pins while the address phases run. All memory-side outputs come straight from flip-flops. The configuration inputs must stay stable while an access is in progress.

Top module: `asram_seq`

## Requirements
- R1: While `rst` is high and after its release with no request, all `mem_ce_n` bits, `mem_oe_n`, `mem_we_n` and `mem_adv_n` are 1 and `req_ack` is 0.
- R2: `mem_adv_n` is 0 for exactly `cfg_aset` consecutive cycles (0 to 15). These cycles start in the cycle after the request is accepted. A value of 0 gives no such cycle, and the next phase starts in that first cycle.
- R3: In multiplexed mode (`cfg_muxed`=1) an address hold phase follows the setup phase. It lasts `cfg_ahld` cycles, where 0 is treated as 1. During hold the chip select is low and `mem_adv_n`, `mem_oe_n` and `mem_we_n` are 1. In separate mode no hold cycle occurs, whatever `cfg_ahld` holds.
- R4: The data setup phase lasts `cfg_dset`+1 cycles (1 to 256). For a read (`req_write`=0), `mem_oe_n` is 0 and `mem_we_n` is 1 in every one of those cycles. For a write, `mem_we_n` is 0 and `mem_oe_n` is 1 in every one of those cycles. The two strobes are never 0 together, and neither is 0 unless a chip select is low.
- R5: Read data is sampled from `mem_dq` in the last data setup cycle. `req_ack` is high for exactly one cycle, the cycle after the last data setup cycle. In that cycle `rd_data` holds the sampled word.
- R6: After data setup, `cfg_turn` cycles (0 to 15) follow with all chip selects and strobes at 1. The ack cycle is the first of them.
- R7: In multiplexed mode, `mem_dq` carries `req_addr[15:0]` during every setup and hold cycle. In both modes, `mem_addr` carries the full `req_addr` from the first setup cycle through the last data setup cycle.
- R8: The block drives `mem_dq` only during write data setup, where it carries `req_wdata`, and during the multiplexed address phases. During read data setup the memory drives the bus without contention.
- R9: `mem_ce_n[b]`, with b=`req_bank`, is 0 from the first setup cycle through the last data setup cycle. The other chip selects stay 1, so at most one bit is 0 at any time.
- R10: From idle, a request sampled at a clock edge starts its first phase in the next cycle. If a request is already waiting when an access acknowledges, the next access's first chip-select cycle comes max(`cfg_turn`,1) cycles after the ack cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present, held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Bank (chip select) index |
| req_addr | input | 26 | Access address |
| req_wdata | input | 16 | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read word, valid with req_ack |
| cfg_muxed | input | 1 | 1 = address and data share the data pins |
| cfg_aset | input | 4 | Address setup cycles, 0 to 15 |
| cfg_ahld | input | 4 | Address hold cycles, 1 to 15 (0 acts as 1) |
| cfg_dset | input | 8 | Data setup cycles minus one |
| cfg_turn | input | 4 | Turnaround cycles, 0 to 15 |
| mem_addr | output | 26 | External address bus |
| mem_dq | inout | 16 | External bidirectional data bus |
| mem_ce_n | output | 4 | Active-low chip selects, one per bank |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_adv_n | output | 1 | Active-low address valid / latch enable |

## Verification
The bench counts, cycle by cycle, how long each strobe stays low at the phase-length extremes. These include zero address setup, which must add no idle cycle, and a 256-cycle data setup. An off-by-one counter load shows up as a setup, hold or data window one cycle too long or too short. A hold code of 0 is used to catch a hold phase that spins through a full wrap. A nonzero hold code is set in separate mode to show the hold phase is ignored there. Back-to-back requests with turnaround values 0, 1, 2 and 15 reveal a block that re-accepts a still-held request or skips the turnaround. Read words and multiplexed address words on the data pins are compared, which exposes a capture in the wrong cycle or a bus driven during a read.

// File: rtl/amc_pkg.sv
package amc_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ASET = 3'd1,
    PH_AHLD = 3'd2,
    PH_DSET = 3'd3,
    PH_TURN = 3'd4
  } phase_e;
endpackage

// File: rtl/amc_phase_ctrl.sv
module amc_phase_ctrl
  import amc_pkg::*;
#(
  parameter int SET_W = 4,
  parameter int DST_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             cfg_muxed,
  input  logic [SET_W-1:0] cfg_aset,
  input  logic [SET_W-1:0] cfg_ahld,
  input  logic [DST_W-1:0] cfg_dset,
  input  logic [SET_W-1:0] cfg_turn,
  output logic             accept,
  output phase_e           phase_q,
  output phase_e           phase_d,
  output logic             cap_en,
  output logic             ack
);
  localparam int CNT_W = (DST_W > SET_W) ? DST_W : SET_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SET_W-1:0] ahld_eff;
  logic             ack_q;

  // hold code 0 behaves as a single cycle
  assign ahld_eff = (cfg_ahld == '0) ? SET_W'(1) : cfg_ahld;
  assign accept   = req_valid && (phase_q == PH_IDLE) && !ack_q;
  assign cap_en   = (phase_q == PH_DSET) && (cnt_q == '0);
  assign ack      = ack_q;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (accept) begin
          if (cfg_aset != '0) begin
            phase_d = PH_ASET;
            cnt_d   = CNT_W'(cfg_aset - SET_W'(1));
          end else if (cfg_muxed) begin
            phase_d = PH_AHLD;
            cnt_d   = CNT_W'(ahld_eff - SET_W'(1));
          end else begin
            phase_d = PH_DSET;
            cnt_d   = CNT_W'(cfg_dset);
          end
        end
      end
      PH_ASET: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - CNT_W'(1);
        end else if (cfg_muxed) begin
          phase_d = PH_AHLD;
          cnt_d   = CNT_W'(ahld_eff - SET_W'(1));
        end else begin
          phase_d = PH_DSET;
          cnt_d   = CNT_W'(cfg_dset);
        end
      end
      PH_AHLD: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - CNT_W'(1);
        end else begin
          phase_d = PH_DSET;
          cnt_d   = CNT_W'(cfg_dset);
        end
      end
      PH_DSET: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - CNT_W'(1);
        end else if (cfg_turn != '0) begin
          phase_d = PH_TURN;
          cnt_d   = CNT_W'(cfg_turn - SET_W'(1));
        end else begin
          phase_d = PH_IDLE;
        end
      end
      PH_TURN: begin
        if (cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
        else             phase_d = PH_IDLE;
      end
      default: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      ack_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      ack_q   <= cap_en;
    end
  end

  // R5: completion is a single-cycle pulse
  a_r5_ack_pulse: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  // R5: completion only follows a data setup cycle
  a_r5_ack_after_data: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> ($past(phase_q) == PH_DSET));

  // R10: no new access starts while the last completion is still visible
  a_r10_no_reaccept: assert property (@(posedge clk) disable iff (rst)
    ack |-> (phase_q != PH_ASET) && (phase_q != PH_AHLD) && (phase_q != PH_DSET));
endmodule

// File: rtl/amc_pin_drive.sv
module amc_pin_drive
  import amc_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16,
  parameter int BANKS  = 4,
  parameter int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  phase_e            phase_d,
  input  logic              cap_en,
  input  logic              cfg_muxed,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BANKS-1:0]  mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_adv_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic [DATA_W-1:0] rd_data
);
  logic              lat_wr;
  logic [BANK_W-1:0] lat_bank;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_wdata;

  logic              cur_wr;
  logic [BANK_W-1:0] cur_bank;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;
  logic [BANKS-1:0]  sel_n;

  logic [ADDR_W-1:0] addr_d;
  logic [BANKS-1:0]  ce_d;
  logic              oe_d, we_d, adv_d, dqe_d;
  logic [DATA_W-1:0] dqo_d;

  // the request being accepted goes straight to the pins in its first phase
  assign cur_wr    = accept ? req_write : lat_wr;
  assign cur_bank  = accept ? req_bank  : lat_bank;
  assign cur_addr  = accept ? req_addr  : lat_addr;
  assign cur_wdata = accept ? req_wdata : lat_wdata;

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    assign sel_n[g] = (cur_bank != BANK_W'(g));
  end

  always_comb begin
    addr_d = mem_addr;
    ce_d   = '1;
    oe_d   = 1'b1;
    we_d   = 1'b1;
    adv_d  = 1'b1;
    dqe_d  = 1'b0;
    dqo_d  = dq_out;
    unique case (phase_d)
      PH_ASET: begin
        addr_d = cur_addr;
        ce_d   = sel_n;
        adv_d  = 1'b0;
        if (cfg_muxed) begin
          dqe_d = 1'b1;
          dqo_d = cur_addr[DATA_W-1:0];
        end
      end
      PH_AHLD: begin
        addr_d = cur_addr;
        ce_d   = sel_n;
        if (cfg_muxed) begin
          dqe_d = 1'b1;
          dqo_d = cur_addr[DATA_W-1:0];
        end
      end
      PH_DSET: begin
        addr_d = cur_addr;
        ce_d   = sel_n;
        if (cur_wr) begin
          we_d  = 1'b0;
          dqe_d = 1'b1;
          dqo_d = cur_wdata;
        end else begin
          oe_d = 1'b0;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_wr    <= 1'b0;
      lat_bank  <= '0;
      lat_addr  <= '0;
      lat_wdata <= '0;
      mem_addr  <= '0;
      mem_ce_n  <= '1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_adv_n <= 1'b1;
      dq_oe     <= 1'b0;
      dq_out    <= '0;
      rd_data   <= '0;
    end else begin
      if (accept) begin
        lat_wr    <= req_write;
        lat_bank  <= req_bank;
        lat_addr  <= req_addr;
        lat_wdata <= req_wdata;
      end
      mem_addr  <= addr_d;
      mem_ce_n  <= ce_d;
      mem_oe_n  <= oe_d;
      mem_we_n  <= we_d;
      mem_adv_n <= adv_d;
      dq_oe     <= dqe_d;
      dq_out    <= dqo_d;
      if (cap_en) rd_data <= dq_in;
    end
  end

  // R9: never more than one bank selected
  a_r9_one_bank: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~mem_ce_n));

  // R4: read and write strobes are exclusive
  a_r4_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n));

  // R4: a strobe is only active with a bank selected
  a_r4_strobe_in_cs: assert property (@(posedge clk) disable iff (rst)
    (!mem_oe_n || !mem_we_n) |-> (mem_ce_n != '1));

  // R8: the block never drives the bus while the memory outputs
  a_r8_no_contention: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> mem_oe_n);
endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import amc_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16,
  parameter int BANKS  = 4,
  parameter int SET_W  = 4,
  parameter int DST_W  = 8,
  parameter int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ack,
  output logic [DATA_W-1:0] rd_data,
  input  logic              cfg_muxed,
  input  logic [SET_W-1:0]  cfg_aset,
  input  logic [SET_W-1:0]  cfg_ahld,
  input  logic [DST_W-1:0]  cfg_dset,
  input  logic [SET_W-1:0]  cfg_turn,
  output logic [ADDR_W-1:0] mem_addr,
  inout  wire  [DATA_W-1:0] mem_dq,
  output logic [BANKS-1:0]  mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_adv_n
);
  logic              accept, cap_en;
  phase_e            phase_q, phase_d;
  logic [DATA_W-1:0] dq_out;
  logic              dq_oe;

  assign mem_dq = dq_oe ? dq_out : {DATA_W{1'bz}};

  amc_phase_ctrl #(.SET_W(SET_W), .DST_W(DST_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .cfg_muxed (cfg_muxed),
    .cfg_aset  (cfg_aset),
    .cfg_ahld  (cfg_ahld),
    .cfg_dset  (cfg_dset),
    .cfg_turn  (cfg_turn),
    .accept    (accept),
    .phase_q   (phase_q),
    .phase_d   (phase_d),
    .cap_en    (cap_en),
    .ack       (req_ack)
  );

  amc_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANKS(BANKS), .BANK_W(BANK_W)) u_pins (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .phase_d   (phase_d),
    .cap_en    (cap_en),
    .cfg_muxed (cfg_muxed),
    .req_write (req_write),
    .req_bank  (req_bank),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .dq_in     (mem_dq),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_adv_n (mem_adv_n),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe),
    .rd_data   (rd_data)
  );

  // R6: the cycle after the data phase ends has no bank selected
  a_r6_idle_after_data: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_DSET && phase_d != PH_DSET) |=> (mem_ce_n == '1));
endmodule

// File: tb/tb_asram_seq.sv
module tb_asram_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_bank = '0;
  logic [25:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ack;
  logic [15:0] rd_data;
  logic        cfg_muxed = 1'b0;
  logic [3:0]  cfg_aset = '0, cfg_ahld = '0, cfg_turn = '0;
  logic [7:0]  cfg_dset = '0;
  logic [25:0] mem_addr;
  wire  [15:0] mem_dq;
  logic [3:0]  mem_ce_n;
  logic        mem_oe_n, mem_we_n, mem_adv_n;

  int n_chk = 0, n_bad = 0;
  int prev_turn = 0;

  always #10 clk = ~clk;

  // memory model: drives a word derived from the address while output enable is low
  assign mem_dq = (mem_oe_n == 1'b0) ? (mem_addr[15:0] ^ 16'hA5C3) : 16'hzzzz;

  asram_seq dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_bank(req_bank), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ack(req_ack), .rd_data(rd_data), .cfg_muxed(cfg_muxed),
    .cfg_aset(cfg_aset), .cfg_ahld(cfg_ahld), .cfg_dset(cfg_dset),
    .cfg_turn(cfg_turn), .mem_addr(mem_addr), .mem_dq(mem_dq),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_adv_n(mem_adv_n)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one access, started in the current timestep; returns at the ack sample
  task automatic do_access(input logic w, input logic [1:0] bank,
                           input logic [25:0] addr, input logic [15:0] wd,
                           input int exp_wait);
    int a_exp, h_exp, d_exp;
    int n_wait = 0, n_adv = 0, n_hold = 0, n_oe = 0, n_we = 0, n_ce = 0;
    int bad_ce = 0, bad_mux = 0, bad_wd = 0, bad_ad = 0, guard = 0;
    bit seen = 0;
    logic [3:0] ce_exp;
    a_exp  = cfg_aset;
    h_exp  = cfg_muxed ? ((cfg_ahld == 0) ? 1 : int'(cfg_ahld)) : 0;
    d_exp  = int'(cfg_dset) + 1;
    ce_exp = ~(4'b0001 << bank);
    req_write = w; req_bank = bank; req_addr = addr; req_wdata = wd;
    req_valid = 1'b1;
    forever begin
      @(negedge clk);
      guard++;
      if (req_ack || guard > 600) break;
      if (mem_ce_n == 4'hF) begin
        if (!seen) n_wait++;
      end else begin
        seen = 1;
        n_ce++;
        if (mem_ce_n !== ce_exp) bad_ce++;
        if (mem_addr !== addr) bad_ad++;
        if (!mem_adv_n) n_adv++;
        if (mem_adv_n && mem_oe_n && mem_we_n) n_hold++;
        if (!mem_oe_n) n_oe++;
        if (!mem_we_n) begin
          n_we++;
          if (mem_dq !== wd) bad_wd++;
        end
        if (cfg_muxed && mem_oe_n && mem_we_n && mem_dq !== addr[15:0]) bad_mux++;
      end
    end
    req_valid = 1'b0;
    check("R10", "cycles before chip select", n_wait, exp_wait);
    check("R2", "address valid cycles", n_adv, a_exp);
    check("R3", "hold cycles", n_hold, h_exp);
    check("R4", "output enable cycles", n_oe, w ? 0 : d_exp);
    check("R4", "write enable cycles", n_we, w ? d_exp : 0);
    check("R9", "chip select cycles", n_ce, a_exp + h_exp + d_exp);
    check("R9", "wrong chip select pattern", bad_ce, 0);
    check("R7", "address bus mismatches", bad_ad, 0);
    check("R5", "ack cycle has chip select released", mem_ce_n, 4'hF);
    if (cfg_muxed) check("R7", "muxed address on data pins", bad_mux, 0);
    if (w) check("R8", "write data on bus", bad_wd, 0);
    else   check("R5", "read data", rd_data, addr[15:0] ^ 16'hA5C3);
    @(negedge clk);
    check("R5", "ack lasts one cycle", req_ack, 1'b0);
    if (cfg_turn >= 2 && !req_valid)
      check("R6", "turnaround keeps strobes idle",
            {mem_ce_n, mem_oe_n, mem_we_n, mem_adv_n}, 7'h7F);
    prev_turn = cfg_turn;
  endtask

  task automatic cfg(input logic mx, input int a, input int h, input int d, input int t);
    cfg_muxed = mx; cfg_aset = 4'(a); cfg_ahld = 4'(h);
    cfg_dset = 8'(d); cfg_turn = 4'(t);
  endtask

  // back-to-back: starts at the ack sample of the previous access
  task automatic chained(input logic w, input logic [1:0] bank,
                         input logic [25:0] addr, input logic [15:0] wd);
    int wexp;
    wexp = (prev_turn < 1) ? 1 : prev_turn;
    // the last negedge of do_access was the cycle after ack: one wait already elapsed
    do_access(w, bank, addr, wd, wexp - 1);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R1", "strobes during reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_adv_n}, 7'h7F);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R1", "strobes after reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_adv_n}, 7'h7F);
    check("R1", "ack after reset", req_ack, 1'b0);
  endtask

  task automatic t_idle_gap;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    t_reset();
    // separate I/O read; hold code set but must be ignored (R3)
    cfg(1'b0, 3, 7, 3, 2);
    do_access(1'b0, 2'd0, 26'h12_3456, 16'h0, 0);
    // separate write, zero setup, single data cycle, zero turnaround
    cfg(1'b0, 0, 0, 0, 0);
    chained(1'b1, 2'd1, 26'h3FF_FFFF, 16'hBEEF);
    // separate read on last bank, turnaround 1
    cfg(1'b0, 0, 5, 0, 1);
    chained(1'b0, 2'd3, 26'h000_0001, 16'h0);
    // multiplexed read
    cfg(1'b1, 2, 3, 4, 1);
    chained(1'b0, 2'd2, 26'h2A_5A5A, 16'h0);
    // multiplexed write at the extremes: hold code 0 acts as 1
    cfg(1'b1, 15, 0, 255, 15);
    chained(1'b1, 2'd0, 26'h15_C0DE, 16'h1234);
    // multiplexed read with zero setup
    cfg(1'b1, 0, 2, 1, 0);
    chained(1'b0, 2'd1, 26'h01_F00F, 16'h0);
    // from idle: multiplexed write with longest hold
    t_idle_gap();
    cfg(1'b1, 1, 15, 2, 3);
    do_access(1'b1, 2'd2, 26'h0ABCDEF, 16'h8001, 0);
    t_idle_gap();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule